// File: doc/BRIEF.md
# Programmable Strobe Timing Controller for an Asynchronous External Bus

This block drives one chip-select region of an asynchronous, memory-style external bus, for pseudo-SRAM style peripherals such as a network controller. Each request on the internal port is a 32-bit word access, a read or a write. The block breaks it into two or four narrow bus cycles, depending on whether the attached device is 16 or 8 bits wide, and runs each bus cycle from a single tick counter. Every strobe edge is a programmable tick offset from the start of that bus cycle.

In multiplexed mode the low address bits share the data pins. An address-valid strobe marks when the address is on the pins. During writes, the write data takes the pins over at a programmable tick. Between requests the block can insert a turnaround gap when the direction changes, and an idle gap. Read data is gathered beat by beat and presented as a whole word together with a one-cycle done pulse.

Top module: `xbus_timing_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, every active-low strobe is high, `xb_doe` is 0, `xb_addr` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: `req_width` equal to 1 selects an 8-bit device: four bus cycles, data on lanes [7:0] with [15:8] driven 0. Any other value selects a 16-bit device with two bus cycles. Beat k carries request bytes starting at byte k*width (least significant first). During beat k, `xb_addr` is `req_addr` + k*width, and it is 0 outside bus cycles.
- R3: Each bus cycle numbers its ticks 0 to length-1. `xb_sel_n` is low exactly for ticks t with `tm_sel_begin` <= t < end, where end is `tm_sel_end_rd` for reads and `tm_sel_end_wr` for writes. It is high outside bus cycles.
- R4: `xb_rd_n` is low exactly for `tm_rd_begin` <= t < `tm_rd_end`, and only in read cycles. `xb_wr_n` is low exactly for `tm_wr_begin` <= t < `tm_wr_end`, and only in write cycles.
- R5: In a read cycle, `xb_din` is sampled at the clock edge that ends tick `tm_sample`. `rsp_done` pulses for one cycle, one clock after the last tick of the last bus cycle, and `rsp_rdata` then holds the assembled word.
- R6: A read bus cycle lasts `tm_rd_len` ticks and a write bus cycle lasts `tm_wr_len` ticks. The beats of one request follow each other with no gap.
- R7: With `mux_mode`=1, `xb_av_n` is low exactly for `tm_av_begin` <= t < end, where end is `tm_av_end_rd` or `tm_av_end_wr` by direction. While it is low and write data is not selected, `xb_doe`=1 and `xb_dout` carries the low 16 bits of the beat address. With `mux_mode`=0, `xb_av_n` stays high.
- R8: Write data is selected in write cycles from tick `tm_data_swap` on when `mux_mode`=1, and for the whole write cycle when `mux_mode`=0. While it is selected, `xb_doe`=1 and `xb_dout` carries the beat's write data, which takes priority over the address. Otherwise `xb_doe`=0.
- R9: The first bus cycle of a request starts exactly G ticks after the accepting clock edge. G is `tm_turn` when the previous request since reset had the other direction (0 otherwise), plus `tm_idle` when `tm_idle_en`=1 and a previous request exists. All strobes stay inactive during the gap.
- R10: `req_ready` is 1 only when no request is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and its inputs are captured then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_width | input | 2 | Device width in bytes (1 = 8-bit, else 16-bit) |
| req_addr | input | AW | Byte address of the word |
| req_wdata | input | 32 | Write word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read word |
| tm_sel_begin | input | 8 | Chip-select assert tick |
| tm_sel_end_rd | input | 8 | Chip-select release tick, reads |
| tm_sel_end_wr | input | 8 | Chip-select release tick, writes |
| tm_av_begin | input | 8 | Address-valid assert tick |
| tm_av_end_rd | input | 8 | Address-valid release tick, reads |
| tm_av_end_wr | input | 8 | Address-valid release tick, writes |
| tm_rd_begin | input | 8 | Output-enable assert tick |
| tm_rd_end | input | 8 | Output-enable release tick |
| tm_wr_begin | input | 8 | Write-enable assert tick |
| tm_wr_end | input | 8 | Write-enable release tick |
| tm_sample | input | 8 | Read data capture tick |
| tm_rd_len | input | 8 | Read bus cycle length in ticks |
| tm_wr_len | input | 8 | Write bus cycle length in ticks |
| tm_data_swap | input | 8 | Tick at which write data replaces the address |
| tm_turn | input | 8 | Direction-change gap in ticks |
| tm_idle | input | 8 | Idle gap in ticks |
| tm_idle_en | input | 1 | Enables the idle gap |
| mux_mode | input | 1 | Address/data sharing the data pins |
| xb_sel_n | output | 1 | Chip-select, active low |
| xb_av_n | output | 1 | Address-valid, active low |
| xb_rd_n | output | 1 | Output-enable, active low |
| xb_wr_n | output | 1 | Write-enable, active low |
| xb_addr | output | AW | Beat byte address |
| xb_dout | output | 16 | Data pins, outgoing value |
| xb_doe | output | 1 | Data pin drive enable |
| xb_din | input | 16 | Data pins, incoming value |

## Verification
A wrong tick or beat counter shows up at once as a strobe edge in the wrong cycle or as a wrong `xb_addr`. The pins are compared every clock against a behavioural model, so the divergence is caught in the cycle it first appears. A wrong gap calculation shifts the first `xb_sel_n` edge of the next request. A wrong capture slot or capture tick leaves no mark on the pins and only shows in `rsp_rdata` at the done pulse. For that reason the bench drives a distinct value on `xb_din` at the sample tick and junk on every other tick.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int TICK_W = 8;
    localparam int WORD_W = 32;
    localparam int BUS_W  = 16;

    typedef logic [TICK_W-1:0] tick_t;
    typedef logic [TICK_W:0]   gap_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GAP  = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    // Cycle-level settings used by the sequencer
    typedef struct packed {
        tick_t rd_len;
        tick_t wr_len;
        tick_t turn;
        tick_t idle;
        logic  idle_en;
    } seq_cfg_t;

    // Edge offsets used by the strobe decoder
    typedef struct packed {
        tick_t sel_b;
        tick_t sel_e_rd;
        tick_t sel_e_wr;
        tick_t av_b;
        tick_t av_e_rd;
        tick_t av_e_wr;
        tick_t rd_b;
        tick_t rd_e;
        tick_t wr_b;
        tick_t wr_e;
        tick_t sample;
        tick_t swap;
        logic  muxed;
    } edge_cfg_t;

    // Active-high internal view of the pin strobes
    typedef struct packed {
        logic sel;
        logic av;
        logic rd;
        logic wr;
    } strobe_t;

    function automatic logic in_window(tick_t t, tick_t on, tick_t off);
        return (t >= on) && (t < off);
    endfunction

    function automatic logic width_is_byte(logic [1:0] w);
        return w == 2'd1;
    endfunction

    function automatic logic [1:0] last_beat(logic narrow);
        return narrow ? 2'd3 : 2'd1;
    endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_cfg_t          cfg,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_width,
    input  logic [AW-1:0]     req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              accept,
    output logic              run,
    output logic              wr,
    output logic              narrow,
    output logic [1:0]        beat,
    output tick_t             tick,
    output logic [AW-1:0]     beat_addr,
    output logic [BUS_W-1:0]  beat_wdata,
    output logic              done
);

    phase_e            phase;
    logic [AW-1:0]     addr_q;
    logic [WORD_W-1:0] wdata_q;
    gap_t              gap_cnt;
    logic              has_prev;
    logic              prev_wr;
    gap_t              gap_new;
    tick_t             len;
    logic              end_tick;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_ready && req_valid;
    assign run       = (phase == PH_RUN);
    assign len       = wr ? cfg.wr_len : cfg.rd_len;
    assign end_tick  = (tick == len - tick_t'(1));

    always_comb begin
        gap_new = '0;
        if (has_prev && (prev_wr != req_write)) gap_new = gap_new + {1'b0, cfg.turn};
        if (has_prev && cfg.idle_en)            gap_new = gap_new + {1'b0, cfg.idle};
    end

    always_comb begin
        if (narrow) begin
            beat_addr  = addr_q + AW'(beat);
            beat_wdata = {8'h00, wdata_q[{beat, 3'b000} +: 8]};
        end else begin
            beat_addr  = addr_q + AW'({beat, 1'b0});
            beat_wdata = wdata_q[{beat[0], 4'b0000} +: 16];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            tick     <= '0;
            beat     <= '0;
            wr       <= 1'b0;
            narrow   <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            gap_cnt  <= '0;
            has_prev <= 1'b0;
            prev_wr  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        wr       <= req_write;
                        narrow   <= width_is_byte(req_width);
                        addr_q   <= req_addr;
                        wdata_q  <= req_wdata;
                        tick     <= '0;
                        beat     <= '0;
                        has_prev <= 1'b1;
                        prev_wr  <= req_write;
                        gap_cnt  <= gap_new;
                        phase    <= (gap_new == '0) ? PH_RUN : PH_GAP;
                    end
                end
                PH_GAP: begin
                    if (gap_cnt == gap_t'(1)) phase <= PH_RUN;
                    gap_cnt <= gap_cnt - gap_t'(1);
                end
                PH_RUN: begin
                    if (end_tick) begin
                        tick <= '0;
                        if (beat == last_beat(narrow)) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            beat <= beat + 2'd1;
                        end
                    end else begin
                        tick <= tick + tick_t'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);
    assert_take_busy_R10: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);
    assert_beat_range_R2: assert property (@(posedge clk) disable iff (rst)
        run |-> (beat <= last_beat(narrow)));

endmodule

// File: rtl/xbus_strobe.sv
module xbus_strobe
    import xbus_pkg::*;
(
    input  edge_cfg_t cfg,
    input  logic      run,
    input  logic      wr,
    input  tick_t     tick,
    output strobe_t   stb,
    output logic      drv_data,
    output logic      sample
);

    always_comb begin
        stb.sel  = run && in_window(tick, cfg.sel_b, wr ? cfg.sel_e_wr : cfg.sel_e_rd);
        stb.av   = run && cfg.muxed && in_window(tick, cfg.av_b, wr ? cfg.av_e_wr : cfg.av_e_rd);
        stb.rd   = run && !wr && in_window(tick, cfg.rd_b, cfg.rd_e);
        stb.wr   = run && wr && in_window(tick, cfg.wr_b, cfg.wr_e);
        drv_data = run && wr && (!cfg.muxed || (tick >= cfg.swap));
        sample   = run && !wr && (tick == cfg.sample);
    end

endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
    import xbus_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              run,
    input  logic              narrow,
    input  logic [1:0]        beat,
    input  logic              av,
    input  logic              drv_data,
    input  logic              sample,
    input  logic [AW-1:0]     beat_addr,
    input  logic [BUS_W-1:0]  beat_wdata,
    input  logic [BUS_W-1:0]  din,
    output logic [AW-1:0]     pin_addr,
    output logic [BUS_W-1:0]  dout,
    output logic              doe,
    output logic [WORD_W-1:0] rdata
);

    assign pin_addr = run ? beat_addr : '0;

    always_comb begin
        if (drv_data) begin
            dout = beat_wdata;
            doe  = 1'b1;
        end else if (av) begin
            dout = BUS_W'(beat_addr);
            doe  = 1'b1;
        end else begin
            dout = '0;
            doe  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rdata <= '0;
        end else if (sample) begin
            if (narrow) rdata[{beat, 3'b000} +: 8]     <= din[7:0];
            else        rdata[{beat[0], 4'b0000} +: 16] <= din;
        end
    end

    assert_no_drive_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !run |-> !doe);

endmodule

// File: rtl/xbus_timing_ctrl.sv
module xbus_timing_ctrl
    import xbus_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_width,
    input  logic [AW-1:0]     req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic [TICK_W-1:0] tm_sel_begin,
    input  logic [TICK_W-1:0] tm_sel_end_rd,
    input  logic [TICK_W-1:0] tm_sel_end_wr,
    input  logic [TICK_W-1:0] tm_av_begin,
    input  logic [TICK_W-1:0] tm_av_end_rd,
    input  logic [TICK_W-1:0] tm_av_end_wr,
    input  logic [TICK_W-1:0] tm_rd_begin,
    input  logic [TICK_W-1:0] tm_rd_end,
    input  logic [TICK_W-1:0] tm_wr_begin,
    input  logic [TICK_W-1:0] tm_wr_end,
    input  logic [TICK_W-1:0] tm_sample,
    input  logic [TICK_W-1:0] tm_rd_len,
    input  logic [TICK_W-1:0] tm_wr_len,
    input  logic [TICK_W-1:0] tm_data_swap,
    input  logic [TICK_W-1:0] tm_turn,
    input  logic [TICK_W-1:0] tm_idle,
    input  logic              tm_idle_en,
    input  logic              mux_mode,
    output logic              xb_sel_n,
    output logic              xb_av_n,
    output logic              xb_rd_n,
    output logic              xb_wr_n,
    output logic [AW-1:0]     xb_addr,
    output logic [BUS_W-1:0]  xb_dout,
    output logic              xb_doe,
    input  logic [BUS_W-1:0]  xb_din
);

    seq_cfg_t          scfg;
    edge_cfg_t         ecfg;
    logic              accept;
    logic              run;
    logic              wr;
    logic              narrow;
    logic [1:0]        beat;
    tick_t             tick;
    logic [AW-1:0]     beat_addr;
    logic [BUS_W-1:0]  beat_wdata;
    strobe_t           stb;
    logic              drv_data;
    logic              sample;

    assign scfg = '{rd_len: tm_rd_len, wr_len: tm_wr_len, turn: tm_turn,
                    idle: tm_idle, idle_en: tm_idle_en};
    assign ecfg = '{sel_b: tm_sel_begin, sel_e_rd: tm_sel_end_rd, sel_e_wr: tm_sel_end_wr,
                    av_b: tm_av_begin, av_e_rd: tm_av_end_rd, av_e_wr: tm_av_end_wr,
                    rd_b: tm_rd_begin, rd_e: tm_rd_end, wr_b: tm_wr_begin, wr_e: tm_wr_end,
                    sample: tm_sample, swap: tm_data_swap, muxed: mux_mode};

    xbus_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg        (scfg),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_width  (req_width),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .accept     (accept),
        .run        (run),
        .wr         (wr),
        .narrow     (narrow),
        .beat       (beat),
        .tick       (tick),
        .beat_addr  (beat_addr),
        .beat_wdata (beat_wdata),
        .done       (rsp_done)
    );

    xbus_strobe u_stb (
        .cfg      (ecfg),
        .run      (run),
        .wr       (wr),
        .tick     (tick),
        .stb      (stb),
        .drv_data (drv_data),
        .sample   (sample)
    );

    xbus_datapath #(.AW(AW)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .clr        (accept),
        .run        (run),
        .narrow     (narrow),
        .beat       (beat),
        .av         (stb.av),
        .drv_data   (drv_data),
        .sample     (sample),
        .beat_addr  (beat_addr),
        .beat_wdata (beat_wdata),
        .din        (xb_din),
        .pin_addr   (xb_addr),
        .dout       (xb_dout),
        .doe        (xb_doe),
        .rdata      (rsp_rdata)
    );

    assign xb_sel_n = !stb.sel;
    assign xb_av_n  = !stb.av;
    assign xb_rd_n  = !stb.rd;
    assign xb_wr_n  = !stb.wr;

    assert_rd_wr_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(!xb_rd_n && !xb_wr_n));
    assert_idle_no_sel_R3: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (xb_sel_n && xb_rd_n && xb_wr_n));
    assert_av_mode_R7: assert property (@(posedge clk) disable iff (rst)
        !mux_mode |-> xb_av_n);
    assert_wr_drives_R8: assert property (@(posedge clk) disable iff (rst)
        (!mux_mode && !xb_wr_n) |-> xb_doe);

endmodule

// File: tb/xbus_timing_ctrl_tb.sv
module xbus_timing_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_width = 2'd2;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic [7:0]  t_sel_b, t_sel_er, t_sel_ew, t_av_b, t_av_er, t_av_ew;
    logic [7:0]  t_rd_b, t_rd_e, t_wr_b, t_wr_e, t_smp, t_rlen, t_wlen, t_swap, t_turn, t_idle;
    logic        t_idle_en, t_mux;
    logic        xb_sel_n, xb_av_n, xb_rd_n, xb_wr_n, xb_doe;
    logic [15:0] xb_addr, xb_dout;
    logic [15:0] xb_din = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    bit has_prev = 0;
    bit prev_wr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_timing_ctrl #(.AW(16)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_width(req_width), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .tm_sel_begin(t_sel_b), .tm_sel_end_rd(t_sel_er), .tm_sel_end_wr(t_sel_ew),
        .tm_av_begin(t_av_b), .tm_av_end_rd(t_av_er), .tm_av_end_wr(t_av_ew),
        .tm_rd_begin(t_rd_b), .tm_rd_end(t_rd_e), .tm_wr_begin(t_wr_b), .tm_wr_end(t_wr_e),
        .tm_sample(t_smp), .tm_rd_len(t_rlen), .tm_wr_len(t_wlen), .tm_data_swap(t_swap),
        .tm_turn(t_turn), .tm_idle(t_idle), .tm_idle_en(t_idle_en), .mux_mode(t_mux),
        .xb_sel_n(xb_sel_n), .xb_av_n(xb_av_n), .xb_rd_n(xb_rd_n), .xb_wr_n(xb_wr_n),
        .xb_addr(xb_addr), .xb_dout(xb_dout), .xb_doe(xb_doe), .xb_din(xb_din)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic bit win(int t, int on, int off);
        return (t >= on) && (t < off);
    endfunction

    // Pins expected when no bus cycle runs
    task automatic chk_quiet(input string tag);
        chk(xb_sel_n && xb_av_n && xb_rd_n && xb_wr_n,
            {tag, " strobes idle"}, {xb_sel_n, xb_av_n, xb_rd_n, xb_wr_n}, 4'hF);
        chk(xb_doe == 1'b0, {tag, " no drive"}, xb_doe, 0);
        chk(xb_addr == 16'h0, {tag, " addr zero"}, xb_addr, 0);
    endtask

    task automatic run_req(input bit wr, input logic [1:0] w, input logic [15:0] a,
                           input logic [31:0] d, input logic [31:0] rdpat);
        int gap;
        int nb;
        int bytes;
        int len;
        bit narrow;
        narrow = (w == 2'd1);
        nb     = narrow ? 4 : 2;
        bytes  = narrow ? 1 : 2;
        len    = wr ? int'(t_wlen) : int'(t_rlen);
        gap    = 0;
        if (has_prev && prev_wr != wr) gap += int'(t_turn);
        if (has_prev && t_idle_en)     gap += int'(t_idle);
        chk(req_ready == 1'b1, "R10 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_width = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 16'hFFFF; req_wdata = 32'hDEADDEAD; req_width = 2'd1;
        for (int g = 0; g < gap; g++) begin
            chk(req_ready == 1'b0, "R10 busy in gap", req_ready, 0);
            chk_quiet("R9 gap");
            @(negedge clk);
        end
        for (int b = 0; b < nb; b++) begin
            logic [15:0] ea;
            logic [15:0] ed;
            ea = a + 16'(b * bytes);
            ed = narrow ? {8'h00, d[b*8 +: 8]} : d[b*16 +: 16];
            for (int t = 0; t < len; t++) begin
                bit e_sel, e_av, e_rd, e_wr, e_dat, e_doe;
                logic [15:0] e_out;
                e_sel = win(t, t_sel_b, wr ? t_sel_ew : t_sel_er);
                e_av  = t_mux && win(t, t_av_b, wr ? t_av_ew : t_av_er);
                e_rd  = !wr && win(t, t_rd_b, t_rd_e);
                e_wr  = wr && win(t, t_wr_b, t_wr_e);
                e_dat = wr && (!t_mux || t >= int'(t_swap));
                e_doe = e_dat || e_av;
                e_out = e_dat ? ed : ea;
                if (!wr && t == int'(t_smp))
                    xb_din = narrow ? {8'hA5, rdpat[b*8 +: 8]} : rdpat[b*16 +: 16];
                else
                    xb_din = 16'h5A5A ^ 16'(t * 257 + b);
                chk(xb_sel_n == !e_sel, "R3 chip-select", xb_sel_n, !e_sel);
                chk(xb_rd_n == !e_rd, "R4 read strobe", xb_rd_n, !e_rd);
                chk(xb_wr_n == !e_wr, "R4 write strobe", xb_wr_n, !e_wr);
                chk(xb_av_n == !e_av, "R7 address-valid", xb_av_n, !e_av);
                chk(xb_doe == e_doe, "R8 drive enable", xb_doe, e_doe);
                if (e_doe) chk(xb_dout == e_out, e_dat ? "R8 write data" : "R7 muxed address",
                               xb_dout, e_out);
                chk(xb_addr == ea, "R2 beat address", xb_addr, ea);
                chk(rsp_done == 1'b0, "R6 no early done", rsp_done, 0);
                @(negedge clk);
            end
        end
        xb_din = 16'h0;
        chk(rsp_done == 1'b1, "R5 done pulse", rsp_done, 1);
        chk(req_ready == 1'b1, "R10 ready at done", req_ready, 1);
        if (!wr) chk(rsp_rdata == rdpat, "R5 read word", rsp_rdata, rdpat);
        chk_quiet("R6 after cycle");
        @(negedge clk);
        chk(rsp_done == 1'b0, "R5 single pulse", rsp_done, 0);
        has_prev = 1;
        prev_wr  = wr;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Configuration A: multiplexed, 6 ns tick values
        t_sel_b = 0;  t_sel_er = 31; t_sel_ew = 31;
        t_av_b  = 2;  t_av_er  = 8;  t_av_ew  = 8;
        t_rd_b  = 9;  t_rd_e   = 28; t_wr_b   = 9; t_wr_e = 28;
        t_smp   = 19; t_rlen   = 31; t_wlen   = 31; t_swap = 15;
        t_turn  = 2;  t_idle   = 3;  t_idle_en = 1; t_mux = 1;
        repeat (3) @(negedge clk);
        chk_quiet("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        chk_quiet("R1 after reset");
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(rsp_done == 1'b0, "R1 done low", rsp_done, 0);

        run_req(1, 2'd2, 16'h0100, 32'h1234_5678, 32'h0);       // R2 wide write, first: no gap (R9)
        run_req(0, 2'd2, 16'h0200, 32'h0, 32'hCAFE_BABE);       // R9 turn + idle
        run_req(0, 2'd1, 16'h0301, 32'h0, 32'h8765_4321);       // R2 byte device, idle only
        run_req(1, 2'd3, 16'h0400, 32'hA1B2_C3D4, 32'h0);       // R2 width 3 acts as 16-bit
        run_req(1, 2'd0, 16'h0500, 32'h0F1E_2D3C, 32'h0);       // R2 width 0 acts as 16-bit
        run_req(1, 2'd1, 16'h06FE, 32'h1122_3344, 32'h0);       // R8 byte write, muxed

        // Configuration B: non-multiplexed, short asymmetric cycles, idle gap off
        t_sel_b = 1;  t_sel_er = 6;  t_sel_ew = 5;
        t_rd_b  = 2;  t_rd_e   = 5;  t_wr_b   = 2; t_wr_e = 4;
        t_smp   = 4;  t_rlen   = 7;  t_wlen   = 6;
        t_turn  = 3;  t_idle   = 1;  t_idle_en = 0; t_mux = 0;
        @(negedge clk);
        run_req(0, 2'd2, 16'h1000, 32'h0, 32'h0BAD_F00D);       // R9 turn only
        run_req(0, 2'd1, 16'h2003, 32'h0, 32'h7E57_C0DE);       // R9 no gap, R5 byte assembly
        run_req(1, 2'd1, 16'h3000, 32'hFACE_0FF1, 32'h0);       // R8 whole-cycle data
        run_req(1, 2'd2, 16'h4000, 32'h5555_AAAA, 32'h0);       // R6 write length
        finish_run();
    end

endmodule